// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches one 16-bit word from a three-wire (Microwire-style) serial configuration EEPROM, so that software no longer has to toggle the memory pins one at a time. The host places a 6-bit word address on `wordAddr` and pulses `startPulse`. The block then drives chip select, serial clock and serial data towards the memory and shifts in the data the memory returns. When the read is complete, the block presents the word on `rdWord` and raises `done` for one cycle.

Every pin change is followed by a programmable wait of `STEP_CLKS` system clocks. This keeps each level on the memory pins above the minimum hold time the memory needs (about 300 ns). Each read has three parts:

- A leading resynchronisation burst with chip select high. This puts the memory's serial state machine into a known state.
- The read itself: an 11-bit command frame followed by 16 clocked data bits.
- A trailing burst identical to the leading one.

Top module: `ee_word_reader`

## Requirements
- R1: After reset, `eeSel`, `eeClk`, `eeMosi`, `busy`, `done` are all 0 and `rdWord` is 0.
- R2: A `startPulse` seen while idle is accepted at that clock edge. `busy` is 1 from the next cycle until the completion cycle. In the completion cycle `busy` is 0 and `done` is 1, and `done` lasts exactly one cycle.
- R3: The leading burst, in steps: select high; clock high; 25 repetitions of (clock low, clock high); clock low; select low; all three memory pins low. `eeMosi` is 0 throughout.
- R4: After the leading burst, the access opens with clock low, then select high. The clock only ever rises while select is high.
- R5: The command frame is the 11-bit value 0x180 OR `wordAddr`, sent bit 10 first. Each bit takes three steps: drive `eeMosi`, then clock high, then clock low. `eeMosi` never changes in the cycle in which the clock rises.
- R6: Sixteen data bits are read MSB first. Each bit takes three steps: clock high; `eeMiso` sampled while the clock is still high, with no pin change; clock low.
- R7: After the data bits, a trailing burst identical in step order to R3 runs. `eeMosi` keeps the last command bit until the final all-low step. `done` comes at the end of that final step, with all memory pins low.
- R8: The first pin change comes one cycle after the accepting edge. Every step holds its pin levels for exactly `STEP_CLKS` clocks, so a read takes 193 × `STEP_CLKS` cycles from acceptance to `done`.
- R9: A `startPulse` while `busy` is 1 is ignored. The pin trace and the returned word belong to the read already in progress.
- R10: `rdWord` changes only in a cycle where `done` is 1, and holds its value through the next read until that read's `done`.
- R11: At `done`, `rdWord` equals the 16-bit word the memory returned for the requested address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle request to read a word |
| wordAddr | input | 6 | Word address, captured when the start is accepted |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle completion strobe |
| rdWord | output | 16 | Last word read |
| eeSel | output | 1 | Memory chip select |
| eeClk | output | 1 | Memory serial clock |
| eeMosi | output | 1 | Serial data towards the memory |
| eeMiso | input | 1 | Serial data from the memory |

## Verification
Some properties hold on every cycle, and the assertions check those: the clock rises only under chip select, the data line is steady when the clock rises, sampling happens with the clock high, `done` is a single cycle coinciding with the fall of `busy` and with quiet pins, and `rdWord` is frozen outside `done`. The exact order and length of the 193 steps, the frame contents for each address, the rejection of a start while busy, and the word returned can only be shown by the scenarios. In those scenarios a behavioural reference trace and an EEPROM model in the bench are compared with the pins on every clock.

// File: rtl/ee_rd_pkg.sv
package ee_rd_pkg;

  typedef struct packed {
    logic setCs;
    logic clrCs;
    logic setSk;
    logic clrSk;
    logic driveDi;
    logic clearAll;
    logic loadCmd;
    logic sampleBit;
    logic publish;
  } eeStrobes_t;

  typedef enum logic [4:0] {
    ST_OFF,
    ST_IA_CS,
    ST_IA_SKH,
    ST_IA_LO,
    ST_IA_HI,
    ST_IA_SKL,
    ST_IA_CSL,
    ST_IA_ZERO,
    ST_AC_SKL,
    ST_AC_CS,
    ST_CM_DI,
    ST_CM_HI,
    ST_CM_LO,
    ST_RD_HI,
    ST_RD_SMP,
    ST_RD_LO
  } eeState_t;

endpackage

// File: rtl/ee_rd_ctrl.sv
module ee_rd_ctrl
  import ee_rd_pkg::*;
#(
  parameter int STEP_CLKS   = 16,
  parameter int RESYNC_CLKS = 25,
  parameter int CMD_W       = 11,
  parameter int DATA_W      = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  output eeStrobes_t strb,
  output logic       busy,
  output logic       done
);

  localparam int LOOP_A   = (RESYNC_CLKS > CMD_W) ? RESYNC_CLKS : CMD_W;
  localparam int LOOP_MAX = (LOOP_A > DATA_W) ? LOOP_A : DATA_W;
  localparam int LOOP_W   = $clog2(LOOP_MAX + 1);
  localparam int STEP_W   = $clog2(STEP_CLKS + 1);
  localparam logic [LOOP_W-1:0] RESYNC_LAST = LOOP_W'(RESYNC_CLKS - 1);
  localparam logic [LOOP_W-1:0] CMD_LAST    = LOOP_W'(CMD_W - 1);
  localparam logic [LOOP_W-1:0] DATA_LAST   = LOOP_W'(DATA_W - 1);
  localparam logic [STEP_W-1:0] STEP_LAST   = STEP_W'(STEP_CLKS - 1);

  eeState_t          state;
  logic [STEP_W-1:0] stepCnt;
  logic [LOOP_W-1:0] loopCnt;
  logic              tailPhase;
  logic              stepFirst;
  logic              stepLast;

  assign busy      = (state != ST_OFF);
  assign stepFirst = busy && (stepCnt == '0);
  assign stepLast  = busy && (stepCnt == STEP_LAST);

  always_comb begin
    strb = '0;
    if (stepFirst) begin
      case (state)
        ST_IA_CS:   strb.setCs     = 1'b1;
        ST_IA_SKH:  strb.setSk     = 1'b1;
        ST_IA_LO:   strb.clrSk     = 1'b1;
        ST_IA_HI:   strb.setSk     = 1'b1;
        ST_IA_SKL:  strb.clrSk     = 1'b1;
        ST_IA_CSL:  strb.clrCs     = 1'b1;
        ST_IA_ZERO: strb.clearAll  = 1'b1;
        ST_AC_SKL:  strb.clrSk     = 1'b1;
        ST_AC_CS:   strb.setCs     = 1'b1;
        ST_CM_DI:   strb.driveDi   = 1'b1;
        ST_CM_HI:   strb.setSk     = 1'b1;
        ST_CM_LO:   strb.clrSk     = 1'b1;
        ST_RD_HI:   strb.setSk     = 1'b1;
        ST_RD_SMP:  strb.sampleBit = 1'b1;
        ST_RD_LO:   strb.clrSk     = 1'b1;
        default:    ;
      endcase
    end
    strb.loadCmd = (state == ST_OFF) && startPulse;
    strb.publish = (state == ST_IA_ZERO) && tailPhase && stepLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_OFF;
      stepCnt   <= '0;
      loopCnt   <= '0;
      tailPhase <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= strb.publish;
      if (state == ST_OFF) begin
        stepCnt <= '0;
        if (startPulse) begin
          state     <= ST_IA_CS;
          tailPhase <= 1'b0;
          loopCnt   <= '0;
        end
      end else if (!stepLast) begin
        stepCnt <= stepCnt + 1'b1;
      end else begin
        stepCnt <= '0;
        case (state)
          ST_IA_CS:  state <= ST_IA_SKH;
          ST_IA_SKH: begin
            state   <= ST_IA_LO;
            loopCnt <= '0;
          end
          ST_IA_LO:  state <= ST_IA_HI;
          ST_IA_HI: begin
            if (loopCnt == RESYNC_LAST) begin
              state <= ST_IA_SKL;
            end else begin
              loopCnt <= loopCnt + 1'b1;
              state   <= ST_IA_LO;
            end
          end
          ST_IA_SKL:  state <= ST_IA_CSL;
          ST_IA_CSL:  state <= ST_IA_ZERO;
          ST_IA_ZERO: state <= tailPhase ? ST_OFF : ST_AC_SKL;
          ST_AC_SKL:  state <= ST_AC_CS;
          ST_AC_CS: begin
            state   <= ST_CM_DI;
            loopCnt <= '0;
          end
          ST_CM_DI:  state <= ST_CM_HI;
          ST_CM_HI:  state <= ST_CM_LO;
          ST_CM_LO: begin
            if (loopCnt == CMD_LAST) begin
              loopCnt <= '0;
              state   <= ST_RD_HI;
            end else begin
              loopCnt <= loopCnt + 1'b1;
              state   <= ST_CM_DI;
            end
          end
          ST_RD_HI:  state <= ST_RD_SMP;
          ST_RD_SMP: state <= ST_RD_LO;
          ST_RD_LO: begin
            if (loopCnt == DATA_LAST) begin
              tailPhase <= 1'b1;
              state     <= ST_IA_CS;
            end else begin
              loopCnt <= loopCnt + 1'b1;
              state   <= ST_RD_HI;
            end
          end
          default: state <= ST_OFF;
        endcase
      end
    end
  end

  // R2: completion strobe is a single cycle
  a_r2_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: busy only drops in the completion cycle
  a_r2_busy_falls_at_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R9: a start while busy causes no new command load
  a_r9_start_ignored_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPulse && !stepLast) |=> busy);

endmodule

// File: rtl/ee_rd_dpath.sv
module ee_rd_dpath
  import ee_rd_pkg::*;
#(
  parameter int                ADDR_W  = 6,
  parameter int                CMD_W   = 11,
  parameter int                DATA_W  = 16,
  parameter logic [CMD_W-1:0]  READ_OP = 11'h180
) (
  input  logic              clk,
  input  logic              rstN,
  input  eeStrobes_t        strb,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic              eeMiso,
  output logic              eeSel,
  output logic              eeClk,
  output logic              eeMosi,
  output logic [DATA_W-1:0] rdWord
);

  localparam int PAD_W = CMD_W - ADDR_W;

  logic [CMD_W-1:0]  cmdSh;
  logic [DATA_W-1:0] rxSh;
  logic [CMD_W-1:0]  frameWord;

  generate
    if (PAD_W > 0) begin : g_pad
      assign frameWord = READ_OP | {{PAD_W{1'b0}}, wordAddr};
    end else begin : g_nopad
      assign frameWord = READ_OP | wordAddr[CMD_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eeSel  <= 1'b0;
      eeClk  <= 1'b0;
      eeMosi <= 1'b0;
      cmdSh  <= '0;
      rxSh   <= '0;
      rdWord <= '0;
    end else begin
      if (strb.clearAll) begin
        eeSel  <= 1'b0;
        eeClk  <= 1'b0;
        eeMosi <= 1'b0;
      end
      if (strb.setCs) eeSel <= 1'b1;
      if (strb.clrCs) eeSel <= 1'b0;
      if (strb.setSk) eeClk <= 1'b1;
      if (strb.clrSk) eeClk <= 1'b0;
      if (strb.loadCmd) cmdSh <= frameWord;
      if (strb.driveDi) begin
        eeMosi <= cmdSh[CMD_W-1];
        cmdSh  <= {cmdSh[CMD_W-2:0], 1'b0};
      end
      if (strb.sampleBit) rxSh <= {rxSh[DATA_W-2:0], eeMiso};
      if (strb.publish) rdWord <= rxSh;
    end
  end

  // R4: serial clock rises only with chip select asserted
  a_r4_clk_rise_selected: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eeClk) |-> eeSel);

  // R5: data line steady on the cycle the clock rises
  a_r5_di_steady_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eeClk) |-> $stable(eeMosi));

  // R6: returned data is sampled while the clock is high
  a_r6_sample_while_high: assert property (@(posedge clk) disable iff (!rstN)
    strb.sampleBit |-> eeClk);

endmodule

// File: rtl/ee_word_reader.sv
module ee_word_reader
  import ee_rd_pkg::*;
#(
  parameter int STEP_CLKS   = 16,
  parameter int RESYNC_CLKS = 25,
  parameter int ADDR_W      = 6,
  parameter int CMD_W       = 11,
  parameter int DATA_W      = 16,
  parameter logic [CMD_W-1:0] READ_OP = 11'h180
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [ADDR_W-1:0] wordAddr,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdWord,
  output logic              eeSel,
  output logic              eeClk,
  output logic              eeMosi,
  input  logic              eeMiso
);

  eeStrobes_t strb;

  ee_rd_ctrl #(
    .STEP_CLKS  (STEP_CLKS),
    .RESYNC_CLKS(RESYNC_CLKS),
    .CMD_W      (CMD_W),
    .DATA_W     (DATA_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .strb      (strb),
    .busy      (busy),
    .done      (done)
  );

  ee_rd_dpath #(
    .ADDR_W (ADDR_W),
    .CMD_W  (CMD_W),
    .DATA_W (DATA_W),
    .READ_OP(READ_OP)
  ) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wordAddr(wordAddr),
    .eeMiso  (eeMiso),
    .eeSel   (eeSel),
    .eeClk   (eeClk),
    .eeMosi  (eeMosi),
    .rdWord  (rdWord)
  );

  // R10: returned word only moves in the completion cycle
  a_r10_word_held: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(rdWord));

  // R7: memory pins are all low when completion is signalled
  a_r7_pins_quiet_at_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!eeSel && !eeClk && !eeMosi));

endmodule

// File: tb/ee_word_reader_tb.sv
module ee_word_reader_tb_top;

  localparam int STEP = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [5:0]  wordAddr = '0;
  logic        busy, done, eeSel, eeClk, eeMosi;
  logic        eeMiso = 1'b0;
  logic [15:0] rdWord;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  ee_word_reader #(.STEP_CLKS(STEP)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .wordAddr(wordAddr),
    .busy(busy), .done(done), .rdWord(rdWord),
    .eeSel(eeSel), .eeClk(eeClk), .eeMosi(eeMosi), .eeMiso(eeMiso)
  );

  function automatic logic [15:0] memWord(input logic [5:0] a);
    logic [15:0] t;
    t = {10'b0, a} * 16'd2741;
    return t ^ 16'hB5C3;
  endfunction

  // ---------------- EEPROM behavioural model ----------------
  int          mState = 0;
  int          mCnt = 0;
  logic [7:0]  mSh = '0;
  logic        prevSk = 1'b0;

  always @(negedge clk) begin
    if (!eeSel) begin
      mState = 0;
      mCnt   = 0;
      eeMiso = 1'b0;
    end else if (eeClk && !prevSk) begin
      case (mState)
        0: if (eeMosi) begin mState = 1; mCnt = 0; mSh = '0; end
        1: begin
          mSh  = {mSh[6:0], eeMosi};
          mCnt = mCnt + 1;
          if (mCnt == 8) begin
            mState = (mSh[7:6] == 2'b10) ? 2 : 3;
            mCnt   = 0;
          end
        end
        2: begin
          eeMiso = memWord(mSh[5:0])[15 - mCnt];
          mCnt   = mCnt + 1;
          if (mCnt == 16) mState = 3;
        end
        default: ;
      endcase
    end
    prevSk = eeClk;
  end

  // ---------------- reference trace ----------------
  logic [2:0]  stepQ[$];
  string       tagQ[$];
  logic [2:0]  cur;
  bit          refBusy = 0;
  int          m = 0;
  logic [5:0]  refAddr = '0;
  logic [15:0] expWord = '0;
  bit          ignoredSeen = 0;

  function automatic void pushStep(string t);
    stepQ.push_back(cur);
    tagQ.push_back(t);
  endfunction

  function automatic void burst(string t);
    cur[2] = 1'b1; pushStep(t);
    cur[1] = 1'b1; pushStep(t);
    for (int i = 0; i < 25; i++) begin
      cur[1] = 1'b0; pushStep(t);
      cur[1] = 1'b1; pushStep(t);
    end
    cur[1] = 1'b0; pushStep(t);
    cur[2] = 1'b0; pushStep(t);
    cur = 3'b000;  pushStep(t);
  endfunction

  function automatic void buildTrace(input logic [5:0] a);
    logic [10:0] frame;
    stepQ.delete();
    tagQ.delete();
    cur = 3'b000;
    burst("R3");
    cur[1] = 1'b0; pushStep("R4");
    cur[2] = 1'b1; pushStep("R4");
    frame = 11'h180 | {5'b0, a};
    for (int b = 10; b >= 0; b--) begin
      cur[0] = frame[b]; pushStep("R5");
      cur[1] = 1'b1;     pushStep("R5");
      cur[1] = 1'b0;     pushStep("R5");
    end
    for (int k = 0; k < 16; k++) begin
      cur[1] = 1'b1; pushStep("R6");
      pushStep("R6");
      cur[1] = 1'b0; pushStep("R6");
    end
    burst("R7");
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      refBusy = 0;
      m = 0;
    end else begin
      if (refBusy && m == stepQ.size() * STEP) refBusy = 0;
      if (refBusy) m = m + 1;
      else if (startPulse) begin
        refBusy = 1;
        m = 0;
        refAddr = wordAddr;
        buildTrace(wordAddr);
      end
    end
  end

  always @(negedge clk) begin
    logic [2:0] expPins;
    logic       expBusy, expDone;
    string      t;
    int         total;
    total   = stepQ.size() * STEP;
    expPins = 3'b000;
    t       = "R1";
    expBusy = refBusy && (m < total);
    expDone = refBusy && (m == total);
    if (refBusy && m >= 1 && m <= total) begin
      expPins = stepQ[(m - 1) / STEP];
      t       = tagQ[(m - 1) / STEP];
    end
    compared++;
    if ({eeSel, eeClk, eeMosi} !== expPins) begin
      mismatched++;
      $display("FAIL %s (R8 step timing) m=%0d pins act=%b exp=%b", t, m, {eeSel, eeClk, eeMosi}, expPins);
    end
    compared++;
    if (busy !== expBusy || done !== expDone) begin
      mismatched++;
      $display("FAIL R2 m=%0d busy/done act=%b%b exp=%b%b", m, busy, done, expBusy, expDone);
    end
    if (expDone) begin
      expWord = memWord(refAddr);
      compared++;
      if (rdWord !== expWord) begin
        mismatched++;
        $display("FAIL %s word act=%h exp=%h", ignoredSeen ? "R9 R11" : "R11", rdWord, expWord);
      end
      ignoredSeen = 0;
    end else begin
      compared++;
      if (rdWord !== expWord) begin
        mismatched++;
        $display("FAIL %s word held act=%h exp=%h", rstN ? "R10" : "R1", rdWord, expWord);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic readAt(input logic [5:0] a, input bit poke);
    @(posedge clk); #2;
    startPulse = 1'b1;
    wordAddr   = a;
    @(posedge clk); #2;
    startPulse = 1'b0;
    if (poke) begin
      repeat (120) @(posedge clk);
      #2;
      ignoredSeen = 1;
      startPulse  = 1'b1;
      wordAddr    = ~a;
      @(posedge clk); #2;
      startPulse = 1'b0;
    end
    do @(negedge clk); while (!done);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #2 rstN = 1'b1;
    repeat (3) @(posedge clk);
    readAt(6'h00, 0);
    readAt(6'h3F, 0);
    repeat (7) @(posedge clk);
    readAt(6'h2A, 1);
    // back-to-back: start driven in the completion cycle
    startPulse = 1'b1;
    wordAddr   = 6'h15;
    @(posedge clk); #2;
    startPulse = 1'b0;
    do @(negedge clk); while (!done);
    readAt(6'h01, 0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog R2 act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule